// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Flags

This block is the arithmetic core of a small 8-bit datapath. One operand always comes from an internal accumulator and the other from an operand input. On each cycle where the load strobe is high, the selected operation runs and the result is written back into the accumulator. A packed status byte is updated in the same edge. The operations are add, add with carry, subtract, subtract with borrow, increment, decrement, AND, OR, XOR, accumulator complement, and one-bit circular rotate in either direction.

The status byte holds five flags at fixed bit positions. The other three positions always read as zero. Sign, zero, even parity, nibble carry and carry are each produced or kept according to the operation class. A 16-bit status word joins the accumulator and the status byte so that both can be saved and restored as a unit. The accumulator can be loaded with any value in two steps: an AND with zero, then an OR with the value.

Top module: `acc_alu`

## Requirements
- R1: While rst_ni is low, acc_o and flags_o are 0x00. Both registers reset asynchronously.
- R2: While load_i is low, acc_o and flags_o keep their values, whatever op_i and operand_i are.
- R3: The status byte places sign at bit 7, zero at bit 6, nibble carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0.
- R4: psw_o carries acc_o in bits 15:8 and flags_o in bits 7:0 at all times.
- R5: Add (op 0) writes acc+operand. Add with carry (op 1) writes acc+operand+carry. Carry receives the carry out of bit 7. Nibble carry receives the carry out of bit 3.
- R6: Subtract (op 2) writes acc−operand. Subtract with borrow (op 3) writes acc−operand−carry. Carry is set on a borrow out of bit 7. Nibble carry is the carry out of bit 3 of acc + ~operand + (op 2 ? 1 : ~carry).
- R7: After any of ops 0 to 8, sign equals bit 7 of the new accumulator. Zero is set when the new accumulator is zero. Parity is set when it holds an even number of ones.
- R8: Increment (op 4) and decrement (op 5) leave carry unchanged. Increment sets nibble carry when the low nibble was 0xF. Decrement sets nibble carry when the low nibble was not 0x0.
- R9: AND (op 6), OR (op 7) and XOR (op 8) with the operand clear carry and nibble carry.
- R10: Complement (op 9) inverts the accumulator and leaves every flag unchanged.
- R11: Rotate left (op 10) moves bit 7 into bit 0 and into carry. Rotate right (op 11) moves bit 0 into bit 7 and into carry. No other flag changes.
- R12: Op codes 12 to 15 with load_i high change neither acc_o nor flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation select |
| operand_i | input | 8 | Second operand |
| load_i | input | 1 | Execute the selected operation this cycle |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Packed status byte |
| psw_o | output | 16 | Accumulator and status byte joined |

## Verification
The assertions assume that op_i and operand_i are stable around the rising edge whenever load_i is high. They also assume that a load sample is taken only after rst_ni has been high for at least one edge, because every property compares against $past of the ports. The bench changes inputs only on the falling edge and keeps load_i high for exactly one rising edge per operation. It chains operations so that each result becomes the starting state of the next, and every undefined op code is sent with load high.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 8;

  localparam logic [OP_W-1:0] OP_ADD = 4'd0;
  localparam logic [OP_W-1:0] OP_ADC = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB = 4'd2;
  localparam logic [OP_W-1:0] OP_SBB = 4'd3;
  localparam logic [OP_W-1:0] OP_INC = 4'd4;
  localparam logic [OP_W-1:0] OP_DEC = 4'd5;
  localparam logic [OP_W-1:0] OP_AND = 4'd6;
  localparam logic [OP_W-1:0] OP_OR  = 4'd7;
  localparam logic [OP_W-1:0] OP_XOR = 4'd8;
  localparam logic [OP_W-1:0] OP_CMA = 4'd9;
  localparam logic [OP_W-1:0] OP_RLC = 4'd10;
  localparam logic [OP_W-1:0] OP_RRC = 4'd11;

  localparam int F_S  = 7;
  localparam int F_Z  = 6;
  localparam int F_AC = 4;
  localparam int F_P  = 2;
  localparam int F_CY = 0;

  function automatic logic is_arith(input logic [OP_W-1:0] op);
    return op <= OP_DEC;
  endfunction

  function automatic logic is_bitwise(input logic [OP_W-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic [FLAG_W-1:0] pack_flags(input logic s, input logic z,
                                                   input logic ac, input logic p,
                                                   input logic cy);
    logic [FLAG_W-1:0] f;
    f       = '0;
    f[F_S]  = s;
    f[F_Z]  = z;
    f[F_AC] = ac;
    f[F_P]  = p;
    f[F_CY] = cy;
    return f;
  endfunction
endpackage

// File: rtl/acc_alu_arith.sv
`timescale 1ns/1ps
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            cy_i,
  output logic [DW-1:0]   res_o,
  output logic            cy_o,
  output logic            ac_o
);
  localparam int NIB = 4;

  logic [DW-1:0] b_eff;
  logic          cin;
  logic          borrow_mode;
  logic [DW:0]   sum;

  always_comb begin
    b_eff       = b_i;
    cin         = 1'b0;
    borrow_mode = 1'b0;
    unique case (op_i)
      OP_ADC: cin = cy_i;
      OP_SUB: begin b_eff = ~b_i; cin = 1'b1;  borrow_mode = 1'b1; end
      OP_SBB: begin b_eff = ~b_i; cin = ~cy_i; borrow_mode = 1'b1; end
      OP_INC: begin b_eff = '0;   cin = 1'b1; end
      OP_DEC: begin b_eff = '1;   cin = 1'b0; end
      default: ;
    endcase
  end

  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
  assign res_o = sum[DW-1:0];
  // carry out of the top bit becomes a borrow in subtract mode
  assign cy_o  = sum[DW] ^ borrow_mode;
  // carry into bit NIB recovered from the sum and the two addends
  assign ac_o  = a_i[NIB] ^ b_eff[NIB] ^ sum[NIB];
endmodule

// File: rtl/acc_alu_logic.sv
`timescale 1ns/1ps
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   res_o,
  output logic            out_bit_o
);
  always_comb begin
    res_o     = a_i;
    out_bit_o = 1'b0;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CMA: res_o = ~a_i;
      OP_RLC: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; out_bit_o = a_i[DW-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[DW-1:1]};    out_bit_o = a_i[0];    end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_szp.sv
`timescale 1ns/1ps
module acc_alu_szp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] res_i,
  output logic          s_o,
  output logic          z_o,
  output logic          p_o
);
  assign s_o = res_i[DW-1];
  assign z_o = (res_i == '0);
  assign p_o = ~^res_i;  // even number of ones
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DW-1:0]     operand_i,
  input  logic              load_i,
  output logic [DW-1:0]     acc_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [DW+FLAG_W-1:0] psw_o
);
  logic [DW-1:0]     acc_q, acc_d;
  logic [FLAG_W-1:0] flg_q, flg_d;

  logic [DW-1:0] ar_res, lg_res;
  logic          ar_cy, ar_ac, lg_bit;
  logic          s_n, z_n, p_n;

  acc_alu_arith #(.DW(DW)) u_arith (
    .op_i(op_i), .a_i(acc_q), .b_i(operand_i), .cy_i(flg_q[F_CY]),
    .res_o(ar_res), .cy_o(ar_cy), .ac_o(ar_ac)
  );

  acc_alu_logic #(.DW(DW)) u_logic (
    .op_i(op_i), .a_i(acc_q), .b_i(operand_i),
    .res_o(lg_res), .out_bit_o(lg_bit)
  );

  logic [DW-1:0] res_sel;
  assign res_sel = is_arith(op_i) ? ar_res : lg_res;

  acc_alu_szp #(.DW(DW)) u_szp (
    .res_i(res_sel), .s_o(s_n), .z_o(z_n), .p_o(p_n)
  );

  always_comb begin
    acc_d = acc_q;
    flg_d = flg_q;
    if (load_i) begin
      if (is_arith(op_i)) begin
        acc_d = ar_res;
        flg_d = pack_flags(s_n, z_n, ar_ac, p_n,
                           (op_i == OP_INC || op_i == OP_DEC) ? flg_q[F_CY] : ar_cy);
      end else if (is_bitwise(op_i)) begin
        acc_d = lg_res;
        flg_d = pack_flags(s_n, z_n, 1'b0, p_n, 1'b0);
      end else if (op_i == OP_CMA) begin
        acc_d = lg_res;
      end else if (op_i == OP_RLC || op_i == OP_RRC) begin
        acc_d        = lg_res;
        flg_d[F_CY]  = lg_bit;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      flg_q <= '0;
    end else begin
      acc_q <= acc_d;
      flg_q <= flg_d;
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flg_q;
  assign psw_o   = {acc_q, flg_q};
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [DW-1:0]     operand_i,
  input logic              load_i,
  input logic [DW-1:0]     acc_o,
  input logic [FLAG_W-1:0] flags_o
);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(acc_o) && $stable(flags_o)));

  a_r12_undef_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && op_i > OP_RRC) |=> ($stable(acc_o) && $stable(flags_o)));

  a_r5_add_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && op_i == OP_ADD) |=>
      ({flags_o[F_CY], acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(operand_i)})));

  a_r7_szp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (is_arith(op_i) || is_bitwise(op_i))) |=>
      (flags_o[F_S] == acc_o[DW-1] && flags_o[F_Z] == (acc_o == '0) &&
       flags_o[F_P] == ~^acc_o));

  a_r8_cy_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (op_i == OP_INC || op_i == OP_DEC)) |=> $stable(flags_o[F_CY]));

  a_r9_bitwise_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && is_bitwise(op_i)) |=> (!flags_o[F_CY] && !flags_o[F_AC]));

  a_r10_cma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && op_i == OP_CMA) |=> (acc_o == ~$past(acc_o) && $stable(flags_o)));

  a_r11_rlc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && op_i == OP_RLC) |=>
      (acc_o == {$past(acc_o[DW-2:0]), $past(acc_o[DW-1])} &&
       flags_o[F_CY] == $past(acc_o[DW-1]) &&
       flags_o[FLAG_W-1:1] == $past(flags_o[FLAG_W-1:1])));

  a_r3_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[1] == 1'b0));
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .operand_i(operand_i),
  .load_i(load_i), .acc_o(acc_o), .flags_o(flags_o)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [7:0]  opd = '0;
  logic        load = 1'b0;
  logic [7:0]  acc, flg;
  logic [15:0] psw;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  acc_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .operand_i(opd), .load_i(load),
    .acc_o(acc), .flags_o(flg), .psw_o(psw)
  );

  // {op, operand, expected acc, expected flags}; flags = S7 Z6 AC4 P2 CY0
  localparam int N = 18;
  localparam logic [27:0] VEC [N] = '{
    {4'd7,  8'h3A, 8'h3A, 8'h04},  // R9  OR
    {4'd0,  8'hC8, 8'h02, 8'h11},  // R5  ADD carry + nibble carry
    {4'd1,  8'h0F, 8'h12, 8'h14},  // R5  ADC uses carry
    {4'd2,  8'h13, 8'hFF, 8'h85},  // R6  SUB borrow
    {4'd3,  8'h0E, 8'hF0, 8'h94},  // R6  SBB with borrow in
    {4'd4,  8'h00, 8'hF1, 8'h80},  // R8  INC
    {4'd8,  8'hF1, 8'h00, 8'h44},  // R7  XOR to zero
    {4'd5,  8'h00, 8'hFF, 8'h84},  // R8  DEC wrap, CY kept 0
    {4'd10, 8'h00, 8'hFF, 8'h85},  // R11 RLC
    {4'd4,  8'h00, 8'h00, 8'h55},  // R8  INC wrap, CY kept 1
    {4'd7,  8'h81, 8'h81, 8'h84},  // R9  OR clears CY
    {4'd11, 8'h00, 8'hC0, 8'h85},  // R11 RRC
    {4'd9,  8'h00, 8'h3F, 8'h85},  // R10 CMA
    {4'd10, 8'h00, 8'h7E, 8'h84},  // R11 RLC, CY out 0
    {4'd6,  8'h0F, 8'h0E, 8'h00},  // R9  AND, odd parity
    {4'd0,  8'hF2, 8'h00, 8'h55},  // R5  ADD to zero
    {4'd12, 8'h55, 8'h00, 8'h55},  // R12 undefined op
    {4'd11, 8'h00, 8'h00, 8'h54}   // R11 RRC of zero
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [7:0] d, input logic ld);
    @(negedge clk);
    op = o; opd = d; load = ld;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc reset", {8'h00, acc}, 16'h0000);
    check("R1 flags reset", {8'h00, flg}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      do_op(VEC[i][27:24], VEC[i][23:16], 1'b1);
      check($sformatf("R5-R12 vec%0d acc", i), {8'h00, acc}, {8'h00, VEC[i][15:8]});
      check($sformatf("R3/R7 vec%0d flags", i), {8'h00, flg}, {8'h00, VEC[i][7:0]});
      check($sformatf("R4 vec%0d psw", i), psw, VEC[i][15:0]);
    end

    // R2: strobe low leaves both registers alone
    do_op(4'd0, 8'hFF, 1'b1);  // acc 00+FF = FF, flags S,P = 84
    check("R5 setup acc", {8'h00, acc}, 16'h00FF);
    do_op(4'd0, 8'h77, 1'b0);
    check("R2 acc kept", {8'h00, acc}, 16'h00FF);
    check("R2 flags kept", {8'h00, flg}, 16'h0084);

    // R12: remaining undefined codes
    for (int c = 13; c < 16; c++) begin
      do_op(4'(c), 8'h01, 1'b1);
      check("R12 undefined acc", {8'h00, acc}, 16'h00FF);
      check("R12 undefined flags", {8'h00, flg}, 16'h0084);
    end

    // R6: subtract with equal operands, no borrow, nibble carry set
    do_op(4'd2, 8'hFF, 1'b1);
    check("R6 sub equal", psw, 16'h0054);
    // R6: SBB with CY=0 behaves like SUB; 00-01 borrows
    do_op(4'd3, 8'h01, 1'b1);
    check("R6 sbb borrow", psw, 16'hFF85);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", psw, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule